// File: doc/BRIEF.md
# Register-Typed Packed SIMD Arithmetic Unit

This is a purely combinational execution unit for a 32-bit core that runs SIMD arithmetic inside its ordinary integer registers. The number of the destination register, not the opcode, fixes how the 32-bit word is split: its bank selects the element width (8, 16 or 32 bits) and whether the elements are signed or unsigned. One function code then covers add, subtract, halving add and subtract, minimum, maximum and three compares for every element type.

A 2-bit mode field on each operation picks one of three behaviours. It can run plain wrap-around arithmetic. It can force saturation (add and subtract) or rounding (halving operations) for that operation alone. Or it can predicate the elements with the value of register 1, taken either as is or inverted, while a global saturation input sets the arithmetic flavour. Predication never changes the result word. It only clears the per-byte write enables, so a register file that honours them keeps the old destination bytes in disabled elements.

Top module: `simd_regtyped_alu`

## Requirements
- R1: The destination register number sets the element type. Registers 2–7 hold four signed 8-bit elements. Registers 8–15 hold four unsigned 8-bit elements. Registers 16–23 hold two signed 16-bit elements. Registers 24–29 hold two unsigned 16-bit elements. Registers 30, 31, 1 and 0 hold one signed 32-bit element. Element k occupies bits [k*W +: W].
- R2: An operand whose source register number is 0 reads as zero, whatever value is on its data port. Destination register 0 drives all four `wr_en` bits low.
- R3: Function codes are 0 add, 1 subtract, 2 halving add, 3 halving subtract, 4 minimum, 5 maximum, 6 equal, 7 greater-than, 8 less-or-equal. With mode 00, add and subtract wrap modulo 2^W.
- R4: When saturation is in force, add and subtract clamp each element to its range. Signed elements clamp to [-2^(W-1), 2^(W-1)-1]. Unsigned elements clamp to [0, 2^W-1].
- R5: Halving add and subtract give (a±b)/2 at full precision and signedness, rounded toward minus infinity. When rounding is in force, 1 is added before the halving.
- R6: Minimum and maximum compare elements as signed or unsigned, according to the bank.
- R7: A compare writes all ones to an element when the condition holds and all zeros when it does not. The same signedness rule as R6 applies.
- R8: Mode 10 enables an element when bit 0 of that element's field in `mask_val` is 1. Mode 11 uses the bitwise inverse of `mask_val`. `wr_en` has one bit per byte, and every byte of an enabled element is set.
- R9: Mode 01 always forces saturation and rounding. Modes 10 and 11 take them from `sat_global`. Mode 00 never applies them, whatever the value of `sat_global`.
- R10: Function codes 9–15 give a zero result and drive all `wr_en` bits low.
- R11: With mode 00 or 01, a valid function code and a non-zero destination, all four `wr_en` bits are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First operand value |
| src_b | input | 32 | Second operand value |
| src_a_idx | input | 5 | Register number of first operand |
| src_b_idx | input | 5 | Register number of second operand |
| dst_idx | input | 5 | Destination register number (selects element type) |
| func | input | 4 | Function code |
| mode | input | 2 | Predicate / saturation mode field |
| mask_val | input | 32 | Current value of register 1 |
| sat_global | input | 1 | Global saturation/rounding enable |
| result | output | 32 | Packed result word |
| wr_en | output | 4 | Per-byte write enables |

## Verification
The hardest cases to reach from the ports are the overflow corners at the element boundaries. The halving add of two most-negative values must keep its ninth bit. A rounded halving of an odd negative sum must move toward zero by exactly one step. An unsigned subtract that borrows must clamp to zero rather than to the signed minimum. Directed operand words put a different one of these corners in each byte, so a single operation exercises several of them at once. The same words are then replayed under the signed bank, the unsigned bank and each mode, which separates width, signedness and predicate errors.

// File: rtl/simd_rt_pkg.sv
package simd_rt_pkg;

  typedef enum logic [2:0] {
    EK_S8  = 3'd0,
    EK_U8  = 3'd1,
    EK_S16 = 3'd2,
    EK_U16 = 3'd3,
    EK_S32 = 3'd4
  } elem_kind_e;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_HADD = 4'd2;
  localparam logic [3:0] OP_HSUB = 4'd3;
  localparam logic [3:0] OP_MIN  = 4'd4;
  localparam logic [3:0] OP_MAX  = 4'd5;
  localparam logic [3:0] OP_SEQ  = 4'd6;
  localparam logic [3:0] OP_SGT  = 4'd7;
  localparam logic [3:0] OP_SLE  = 4'd8;
  localparam logic [3:0] OP_LAST = OP_SLE;

  localparam logic [1:0] MD_PLAIN = 2'b00;
  localparam logic [1:0] MD_FORCE = 2'b01;
  localparam logic [1:0] MD_MASK  = 2'b10;
  localparam logic [1:0] MD_NMASK = 2'b11;

endpackage

// File: rtl/simd_bank_decode.sv
module simd_bank_decode
  import simd_rt_pkg::*;
#(
  parameter int REGW = 5
) (
  input  logic [REGW-1:0] reg_idx,
  output elem_kind_e      kind,
  output logic            is_signed,
  output logic            write_ok
);

  always_comb begin
    if (reg_idx >= REGW'(30))      kind = EK_S32;
    else if (reg_idx >= REGW'(24)) kind = EK_U16;
    else if (reg_idx >= REGW'(16)) kind = EK_S16;
    else if (reg_idx >= REGW'(8))  kind = EK_U8;
    else if (reg_idx >= REGW'(2))  kind = EK_S8;
    else                           kind = EK_S32;
  end

  assign is_signed = (kind == EK_S8) || (kind == EK_S16) || (kind == EK_S32);
  assign write_ok  = (reg_idx != '0);

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_rt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sgn,
  input  logic [3:0]   op,
  input  logic         force_en,
  output logic [W-1:0] res
);

  localparam int EW = W + 2;

  logic [EW-1:0] ea, eb, sum, dif, hsrc, hrnd;
  logic          lt, eq, ovf_add, ovf_sub;
  logic [W-1:0]  maxv, minv, add_v, sub_v;

  assign ea   = {{2{sgn & a[W-1]}}, a};
  assign eb   = {{2{sgn & b[W-1]}}, b};
  assign sum  = ea + eb;
  assign dif  = ea - eb;
  assign lt   = dif[EW-1];
  assign eq   = (a == b);

  assign maxv = sgn ? {1'b0, {(W-1){1'b1}}} : {W{1'b1}};
  assign minv = sgn ? {1'b1, {(W-1){1'b0}}} : {W{1'b0}};

  assign ovf_add = sgn ? (sum[W] != sum[W-1]) : sum[W];
  assign ovf_sub = sgn ? (dif[W] != dif[W-1]) : dif[W];

  always_comb begin
    add_v = sum[W-1:0];
    if (force_en && ovf_add) add_v = (sgn && sum[W]) ? minv : maxv;
  end

  always_comb begin
    sub_v = dif[W-1:0];
    if (force_en && ovf_sub) sub_v = (!sgn || dif[W]) ? minv : maxv;
  end

  assign hsrc = (op == OP_HSUB) ? dif : sum;
  assign hrnd = hsrc + EW'(force_en);

  always_comb begin
    case (op)
      OP_ADD:  res = add_v;
      OP_SUB:  res = sub_v;
      OP_HADD,
      OP_HSUB: res = hrnd[W:1];
      OP_MIN:  res = lt ? a : b;
      OP_MAX:  res = lt ? b : a;
      OP_SEQ:  res = {W{eq}};
      OP_SGT:  res = {W{!lt && !eq}};
      OP_SLE:  res = {W{lt || eq}};
      default: res = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{hrnd[EW-1], hrnd[0], sum[EW-1], dif[W+1]};

endmodule

// File: rtl/simd_lane_mask.sv
module simd_lane_mask
  import simd_rt_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  elem_kind_e        kind,
  input  logic [1:0]        mode,
  input  logic [XLEN-1:0]   mask_val,
  input  logic              sat_global,
  input  logic              write_ok,
  input  logic              op_valid,
  output logic              force_en,
  output logic [XLEN/8-1:0] wr_en
);

  localparam int NB = XLEN / 8;

  logic [XLEN-1:0] emask;
  logic [NB-1:0]   en;

  assign emask = mode[1] ? (mode[0] ? ~mask_val : mask_val) : {XLEN{1'b1}};

  always_comb begin
    case (mode)
      MD_FORCE:          force_en = 1'b1;
      MD_MASK, MD_NMASK: force_en = sat_global;
      default:           force_en = 1'b0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      case (kind)
        EK_S8, EK_U8:   en[i] = emask[8*i];
        EK_S16, EK_U16: en[i] = emask[16*(i/2)];
        default:        en[i] = emask[0];
      endcase
    end
  end

  assign wr_en = en & {NB{write_ok & op_valid}};

endmodule

// File: rtl/simd_regtyped_alu.sv
module simd_regtyped_alu
  import simd_rt_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REGW  = 5,
  parameter int FUNCW = 4
) (
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [REGW-1:0]   src_a_idx,
  input  logic [REGW-1:0]   src_b_idx,
  input  logic [REGW-1:0]   dst_idx,
  input  logic [FUNCW-1:0]  func,
  input  logic [1:0]        mode,
  input  logic [XLEN-1:0]   mask_val,
  input  logic              sat_global,
  output logic [XLEN-1:0]   result,
  output logic [XLEN/8-1:0] wr_en
);

  localparam int N8  = XLEN / 8;
  localparam int N16 = XLEN / 16;

  elem_kind_e      kind;
  logic            sgn, write_ok, force_en, op_valid;
  logic [XLEN-1:0] a_eff, b_eff, r8, r16, r32;
  logic [3:0]      op;

  assign a_eff    = (src_a_idx == '0) ? '0 : src_a;
  assign b_eff    = (src_b_idx == '0) ? '0 : src_b;
  assign op       = 4'(func);
  assign op_valid = (func <= FUNCW'(OP_LAST));

  simd_bank_decode #(.REGW(REGW)) u_dec (
    .reg_idx   (dst_idx),
    .kind      (kind),
    .is_signed (sgn),
    .write_ok  (write_ok)
  );

  simd_lane_mask #(.XLEN(XLEN)) u_mask (
    .kind       (kind),
    .mode       (mode),
    .mask_val   (mask_val),
    .sat_global (sat_global),
    .write_ok   (write_ok),
    .op_valid   (op_valid),
    .force_en   (force_en),
    .wr_en      (wr_en)
  );

  for (genvar i = 0; i < N8; i++) begin : g_l8
    simd_lane_alu #(.W(8)) u_alu (
      .a(a_eff[8*i +: 8]), .b(b_eff[8*i +: 8]), .sgn(sgn), .op(op),
      .force_en(force_en), .res(r8[8*i +: 8])
    );
  end

  for (genvar j = 0; j < N16; j++) begin : g_l16
    simd_lane_alu #(.W(16)) u_alu (
      .a(a_eff[16*j +: 16]), .b(b_eff[16*j +: 16]), .sgn(sgn), .op(op),
      .force_en(force_en), .res(r16[16*j +: 16])
    );
  end

  simd_lane_alu #(.W(XLEN)) u_l32 (
    .a(a_eff), .b(b_eff), .sgn(sgn), .op(op),
    .force_en(force_en), .res(r32)
  );

  always_comb begin
    case (kind)
      EK_S8, EK_U8:   result = r8;
      EK_S16, EK_U16: result = r16;
      default:        result = r32;
    endcase
  end

endmodule

// File: rtl/simd_regtyped_alu_chk.sv
module simd_regtyped_alu_chk #(
  parameter int XLEN  = 32,
  parameter int REGW  = 5,
  parameter int FUNCW = 4
) (
  input logic [REGW-1:0]   dst_idx,
  input logic [FUNCW-1:0]  func,
  input logic [1:0]        mode,
  input logic [XLEN-1:0]   result,
  input logic [XLEN/8-1:0] wr_en
);

  logic is16, is32, fvalid;
  assign is16   = (dst_idx >= REGW'(16)) && (dst_idx < REGW'(30));
  assign is32   = (dst_idx >= REGW'(30)) || (dst_idx < REGW'(2));
  assign fvalid = (func <= FUNCW'(8));

  always_comb begin
    AST_ZERO_DEST_SILENT: assert (dst_idx != '0 || wr_en == '0)
      else $error("write enable toward register 0");  // R2
    AST_RESERVED_SILENT: assert (fvalid || (wr_en == '0 && result == '0))
      else $error("reserved function produced output");  // R10
    AST_UNMASKED_FULL: assert (mode[1] || !fvalid || dst_idx == '0 || (&wr_en))
      else $error("unmasked op lost an enable");  // R11
    AST_WE_GROUPED: assert (!is16 || (wr_en[1] == wr_en[0] && wr_en[3] == wr_en[2]))
      else $error("16-bit element enables split");  // R8
    AST_WE_WHOLE: assert (!is32 || wr_en == '0 || (&wr_en))
      else $error("32-bit element enables split");  // R8
  end

  always_comb begin
    for (int k = 0; k < XLEN/8; k++) begin
      AST_CMP_SATURATED_BYTES: assert (!(func >= FUNCW'(6) && fvalid) ||
                                       result[8*k +: 8] == 8'h00 || result[8*k +: 8] == 8'hFF)
        else $error("compare byte not all-zero/all-one");  // R7
    end
  end

endmodule

bind simd_regtyped_alu simd_regtyped_alu_chk #(.XLEN(XLEN), .REGW(REGW), .FUNCW(FUNCW)) u_chk (
  .dst_idx (dst_idx),
  .func    (func),
  .mode    (mode),
  .result  (result),
  .wr_en   (wr_en)
);

// File: tb/simd_regtyped_alu_test.sv
`timescale 1ns/1ps
module simd_regtyped_alu_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] src_a, src_b, mask_val, result;
  logic [4:0]  src_a_idx, src_b_idx, dst_idx;
  logic [3:0]  func, wr_en;
  logic [1:0]  mode;
  logic        sat_global;
  int          n_checks, n_errors;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  simd_regtyped_alu uut (
    .src_a(src_a), .src_b(src_b), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .dst_idx(dst_idx), .func(func), .mode(mode), .mask_val(mask_val),
    .sat_global(sat_global), .result(result), .wr_en(wr_en)
  );

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [4:0] d,
                       input logic [3:0] f, input logic [1:0] m,
                       input logic [31:0] mk, input logic sg);
    @(negedge clk);
    src_a = a; src_b = b; dst_idx = d; func = f; mode = m; mask_val = mk; sat_global = sg;
    #1;
  endtask

  task automatic chk_res(input string req, input logic [31:0] exp);
    n_checks++;
    if (result !== exp) begin
      n_errors++;
      $display("FAIL %s result got %08h expected %08h", req, result, exp);
    end
  endtask

  task automatic chk_we(input string req, input logic [3:0] exp);
    n_checks++;
    if (wr_en !== exp) begin
      n_errors++;
      $display("FAIL %s wr_en got %04b expected %04b", req, wr_en, exp);
    end
  endtask

  task automatic t_reset_state();
    drive(32'h0, 32'h0, 5'd0, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_res("R2 idle", 32'h0);
    chk_we("R2 idle dst0", 4'b0000);
  endtask

  task automatic t_add_wrap_sat();
    drive(32'h7F01_80FF, 32'h0101_FF01, 5'd2, 4'd0, 2'b00, 32'h0, 1'b1);
    chk_res("R3 s8 wrap add", 32'h8002_7F00);
    chk_we("R11 full enables", 4'b1111);
    drive(32'h7F01_80FF, 32'h0101_FF01, 5'd2, 4'd0, 2'b01, 32'h0, 1'b0);
    chk_res("R4 s8 sat add", 32'h7F02_8000);
    drive(32'h7F01_80FF, 32'h0101_FF01, 5'd8, 4'd0, 2'b01, 32'h0, 1'b0);
    chk_res("R4 u8 sat add", 32'h8002_FFFF);
  endtask

  task automatic t_sub();
    drive(32'h0005_1000, 32'h0010_0001, 5'd24, 4'd1, 2'b01, 32'h0, 1'b0);
    chk_res("R4 u16 sat sub", 32'h0000_0FFF);
    drive(32'h0005_1000, 32'h0010_0001, 5'd24, 4'd1, 2'b00, 32'h0, 1'b0);
    chk_res("R3 u16 wrap sub", 32'hFFF5_0FFF);
    drive(32'h8000_7FFF, 32'h0001_FFFF, 5'd16, 4'd1, 2'b01, 32'h0, 1'b0);
    chk_res("R4 s16 sat sub", 32'h8000_7FFF);
  endtask

  task automatic t_halving();
    drive(32'h03FD_7F80, 32'h0000_7F80, 5'd3, 4'd2, 2'b00, 32'h0, 1'b0);
    chk_res("R5 s8 halving add floor", 32'h01FE_7F80);
    drive(32'h03FD_7F80, 32'h0000_7F80, 5'd3, 4'd2, 2'b01, 32'h0, 1'b0);
    chk_res("R5 s8 halving add round", 32'h02FF_7F80);
    drive(32'h03FD_7F80, 32'h0000_7F80, 5'd9, 4'd2, 2'b00, 32'h0, 1'b0);
    chk_res("R5 u8 halving add", 32'h017E_7F80);
    drive(32'h0000_0001, 32'h0000_0004, 5'd30, 4'd3, 2'b00, 32'h0, 1'b0);
    chk_res("R5 s32 halving sub floor", 32'hFFFF_FFFE);
    drive(32'h0000_0001, 32'h0000_0004, 5'd30, 4'd3, 2'b01, 32'h0, 1'b0);
    chk_res("R5 s32 halving sub round", 32'hFFFF_FFFF);
  endtask

  task automatic t_minmax();
    drive(32'h8001_7FFF, 32'h0180_0000, 5'd4, 4'd4, 2'b00, 32'h0, 1'b0);
    chk_res("R6 s8 min", 32'h8080_00FF);
    drive(32'h8001_7FFF, 32'h0180_0000, 5'd12, 4'd4, 2'b00, 32'h0, 1'b0);
    chk_res("R6 u8 min", 32'h0101_0000);
    drive(32'h8001_7FFF, 32'h0180_0000, 5'd12, 4'd5, 2'b00, 32'h0, 1'b0);
    chk_res("R6 u8 max", 32'h8080_7FFF);
  endtask

  task automatic t_compare();
    drive(32'h0001_FFFF, 32'h0001_0002, 5'd25, 4'd6, 2'b00, 32'h0, 1'b0);
    chk_res("R7 u16 equal", 32'hFFFF_0000);
    drive(32'h0001_FFFF, 32'h0001_0002, 5'd25, 4'd7, 2'b00, 32'h0, 1'b0);
    chk_res("R7 u16 greater", 32'h0000_FFFF);
    drive(32'h0001_FFFF, 32'h0001_0002, 5'd17, 4'd7, 2'b00, 32'h0, 1'b0);
    chk_res("R7 s16 greater", 32'h0000_0000);
    drive(32'h0001_FFFF, 32'h0001_0002, 5'd17, 4'd8, 2'b00, 32'h0, 1'b0);
    chk_res("R7 s16 less-or-equal", 32'hFFFF_FFFF);
  endtask

  task automatic t_mask();
    drive(32'h0101_0101, 32'h0101_0101, 5'd5, 4'd0, 2'b10, 32'h0000_0100, 1'b0);
    chk_res("R8 masked result unchanged", 32'h0202_0202);
    chk_we("R8 s8 mask", 4'b0010);
    drive(32'h0101_0101, 32'h0101_0101, 5'd5, 4'd0, 2'b11, 32'h0000_0100, 1'b0);
    chk_we("R8 s8 inverted mask", 4'b1101);
    drive(32'h0101_0101, 32'h0101_0101, 5'd20, 4'd0, 2'b10, 32'h0001_0000, 1'b0);
    chk_we("R8 s16 mask upper", 4'b1100);
    drive(32'h0101_0101, 32'h0101_0101, 5'd20, 4'd0, 2'b10, 32'h0000_0100, 1'b0);
    chk_we("R8 s16 mask non-lsb bit", 4'b0000);
    drive(32'h0101_0101, 32'h0101_0101, 5'd31, 4'd0, 2'b11, 32'h0000_0000, 1'b0);
    chk_we("R8 s32 inverted zero mask", 4'b1111);
  endtask

  task automatic t_global_sat();
    drive(32'h7F00_0000, 32'h0100_0000, 5'd2, 4'd0, 2'b10, 32'hFFFF_FFFF, 1'b1);
    chk_res("R9 global sat on", 32'h7F00_0000);
    drive(32'h7F00_0000, 32'h0100_0000, 5'd2, 4'd0, 2'b10, 32'hFFFF_FFFF, 1'b0);
    chk_res("R9 global sat off", 32'h8000_0000);
    drive(32'h7F00_0000, 32'h0100_0000, 5'd2, 4'd0, 2'b00, 32'hFFFF_FFFF, 1'b1);
    chk_res("R9 plain mode ignores global", 32'h8000_0000);
  endtask

  task automatic t_zero_src();
    src_a_idx = 5'd0;
    drive(32'h1234_5678, 32'h0000_0001, 5'd30, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_res("R2 src reg0 reads zero", 32'h0000_0001);
    src_a_idx = 5'd2;
    drive(32'h1234_5678, 32'h0000_0001, 5'd0, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_we("R2 dst reg0 discarded", 4'b0000);
  endtask

  task automatic t_reserved();
    drive(32'h1111_1111, 32'h2222_2222, 5'd2, 4'd9, 2'b00, 32'h0, 1'b0);
    chk_res("R10 reserved result", 32'h0);
    chk_we("R10 reserved enables", 4'b0000);
  endtask

  task automatic t_banks();
    drive(32'h0000_FFFF, 32'h0000_0001, 5'd29, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_res("R1 reg29 is 16-bit", 32'h0000_0000);
    drive(32'h0000_FFFF, 32'h0000_0001, 5'd30, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_res("R1 reg30 is 32-bit", 32'h0001_0000);
    drive(32'h0000_00FF, 32'h0000_0001, 5'd15, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_res("R1 reg15 is 8-bit", 32'h0000_0000);
    drive(32'h0000_00FF, 32'h0000_0001, 5'd16, 4'd0, 2'b00, 32'h0, 1'b0);
    chk_res("R1 reg16 is 16-bit", 32'h0000_0100);
  endtask

  initial begin
    n_checks = 0; n_errors = 0;
    rst_n = 1'b0;
    src_a = '0; src_b = '0; src_a_idx = 5'd2; src_b_idx = 5'd3;
    dst_idx = '0; func = '0; mode = '0; mask_val = '0; sat_global = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add_wrap_sat();
    t_sub();
    t_halving();
    t_minmax();
    t_compare();
    t_mask();
    t_global_sat();
    t_zero_src();
    t_reserved();
    t_banks();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired got running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule